// File: doc/BRIEF.md
# Single Overflowed-Transaction Controller

This block lets many hardware threads of one process run transactions while allowing at most one of them at a time to run in overflowed mode. Overflowed mode is the slow path a transaction takes once its read and write set no longer fits in on-chip tracking. The block keeps one shared status word for the process and one private status word per thread. The shared word holds an overflow-active flag and the identifier of the live overflow. Each private word holds an overflowed flag, a nesting depth and a no-abort flag. The no-abort flag marks a transaction that runs without an undo log and may therefore perform I/O.

Threads present begin, end, abort and overflow-entry requests. In the same cycle the block answers each one with grant, stall, or neither (refused). When the serialized variant is selected, every thread other than the overflow holder is held for as long as an overflow is active.

A separate check port evaluates the overflow metadata stored with a memory block. The metadata is retired lazily. The block never clears stored bits; it advances the live identifier on every overflow entry instead. Stored bits count only when the shared flag is set and their stamped identifier equals the live one. The port reports conflicts, grants the right to rewrite the metadata, and supplies the merged bits and the identifier to store.

Top module: `solo_ovf_ctrl`

## Requirements
- R1: After reset the shared flag is clear, the live identifier is 0, and every thread's overflowed flag, depth and no-abort flag are 0. No grant, stall or hold is raised while no request is valid.
- R2: Request codes are begin=0, end=1, abort=2, enter-overflow=3. A begin is granted and increments the depth unless the depth is at its maximum (all ones), in which case it is refused with no change. The no-abort flag is loaded from the request's no-abort input on a begin from depth 0.
- R3: An enter-overflow request from a thread with depth at least 1 and the shared flag clear is granted when no lower-indexed thread makes the same request in that cycle. A grant sets the shared flag, records the thread as holder, sets its overflowed flag and increments the live identifier modulo 2^ID_W. At most one thread is ever overflowed.
- R4: An enter-overflow request from a thread that is not yet overflowed stalls while the shared flag is set, or when a lower-indexed thread wins the same cycle. It changes no state. A thread that is already overflowed is granted with no change.
- R5: An end decrements the depth. The end that brings the depth to 0 commits: it clears the thread's no-abort flag and overflowed flag, and, for the holder, clears the shared flag while leaving the live identifier unchanged.
- R6: An abort at depth at least 1 with the no-abort flag clear is granted. It sets the depth to 0, clears the thread's flags and, for the holder, clears the shared flag at once. An abort while the no-abort flag is set is refused with no change.
- R7: With SERIALIZED=1, while the shared flag is set, hold is raised for every thread other than the holder. Any request from such a thread is stalled and changes no state. With SERIALIZED=0, hold stays low.
- R8: Checked metadata is live exactly when the shared flag is set and the stored identifier equals the live one. A conflict is flagged for a valid check when the metadata is live, the requesting thread is not overflowed, and either the stored write bit is set or the access is a write and the stored read bit is set.
- R9: A metadata rewrite is permitted only for a valid check from the overflowed thread that owns the block. The merged read bit is (live and stored read) or (access is a read). The merged write bit is (live and stored write) or (access is a write). Stale stored bits therefore count as empty, and the identifier to stamp is the live one.
- R10: End, abort and enter-overflow requests from a thread at depth 0 are refused: no grant, no stall and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_THREADS | Request valid, one bit per thread |
| req_op_i | input | 2*NUM_THREADS | Request code per thread (begin 0, end 1, abort 2, enter 3) |
| req_noabort_i | input | NUM_THREADS | No-abort flag to load on an outermost begin |
| grant_o | output | NUM_THREADS | Request granted this cycle |
| stall_o | output | NUM_THREADS | Request must be retried later |
| hold_o | output | NUM_THREADS | Thread is held by the serialized variant |
| ovf_active_o | output | 1 | Shared overflow-active flag |
| ovf_id_o | output | ID_W | Live overflow identifier |
| ovf_holder_o | output | $clog2(NUM_THREADS) | Index of the overflow holder |
| thr_ovf_o | output | NUM_THREADS | Per-thread overflowed flag |
| thr_depth_o | output | DEPTH_W*NUM_THREADS | Per-thread nesting depth |
| thr_noabort_o | output | NUM_THREADS | Per-thread no-abort flag |
| chk_valid_i | input | 1 | Metadata check valid |
| chk_tid_i | input | $clog2(NUM_THREADS) | Thread performing the access |
| chk_write_i | input | 1 | Access is a write |
| chk_owner_i | input | 1 | Requester owns the block |
| chk_rd_bit_i | input | 1 | Stored read bit |
| chk_wr_bit_i | input | 1 | Stored write bit |
| chk_id_i | input | ID_W | Stored identifier |
| chk_live_o | output | 1 | Stored metadata is live |
| chk_conflict_o | output | 1 | Access conflicts with the overflow |
| meta_wr_en_o | output | 1 | Requester may rewrite the metadata |
| meta_rd_o | output | 1 | Merged read bit to store |
| meta_wr_o | output | 1 | Merged write bit to store |
| meta_id_o | output | ID_W | Identifier to stamp |

## Verification
The bench builds the block with four threads, a 3-bit identifier, a 2-bit depth and the serialized variant. The short identifier lets nine overflow entries in a row carry it through its wrap back to 0, so stale metadata whose stamp only matches modulo the width can be exercised. The 2-bit depth makes the refused begin at maximum depth reachable within a few requests. Four threads allow simultaneous entry requests in which the winner is not thread 0, as well as held threads in the serialized variant.

// File: rtl/solo_ovf_pkg.sv
package solo_ovf_pkg;
   typedef enum logic [1:0] {
      OP_BEGIN = 2'd0,
      OP_END   = 2'd1,
      OP_ABORT = 2'd2,
      OP_ENTER = 2'd3
   } txn_op_e;
endpackage

// File: rtl/solo_ovf_pick.sv
module solo_ovf_pick #(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS-1:0] cand_i,
   output logic [NUM_THREADS-1:0] win_o
);
   logic [NUM_THREADS:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_chain
      assign seen[i+1] = seen[i] | cand_i[i];
      assign win_o[i]  = cand_i[i] & ~seen[i];
   end
endmodule

// File: rtl/solo_ovf_thread.sv
module solo_ovf_thread
   import solo_ovf_pkg::*;
#(
   parameter int DEPTH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  txn_op_e            req_op_i,
   input  logic               req_noabort_i,
   input  logic               blocked_i,
   input  logic               shared_active_i,
   input  logic               entry_win_i,
   output logic               grant_o,
   output logic               stall_o,
   output logic               entry_cand_o,
   output logic               release_o,
   output logic               ovf_o,
   output logic [DEPTH_W-1:0] depth_o,
   output logic               noabort_o
);
   localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
   localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

   logic [DEPTH_W-1:0] depth_q;
   logic               ovf_q;
   logic               noab_q;
   logic               in_txn;
   logic               commit_end;

   assign in_txn = (depth_q != '0);

   assign entry_cand_o = req_valid_i && !blocked_i && (req_op_i == OP_ENTER)
                         && in_txn && !ovf_q && !shared_active_i;

   always_comb begin
      grant_o = 1'b0;
      stall_o = 1'b0;
      if (req_valid_i) begin
         if (blocked_i) begin
            stall_o = 1'b1;
         end else begin
            unique case (req_op_i)
               OP_BEGIN: grant_o = (depth_q != DEPTH_MAX);
               OP_END:   grant_o = in_txn;
               OP_ABORT: grant_o = in_txn && !noab_q;
               OP_ENTER: begin
                  if (in_txn) begin
                     if (ovf_q) begin
                        grant_o = 1'b1;
                     end else if (shared_active_i) begin
                        stall_o = 1'b1;
                     end else begin
                        grant_o = entry_win_i;
                        stall_o = !entry_win_i;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign commit_end = grant_o && (req_op_i == OP_END) && (depth_q == DEPTH_ONE);
   assign release_o  = ovf_q && (commit_end || (grant_o && (req_op_i == OP_ABORT)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         ovf_q   <= 1'b0;
         noab_q  <= 1'b0;
      end else if (grant_o) begin
         unique case (req_op_i)
            OP_BEGIN: begin
               depth_q <= depth_q + 1'b1;
               if (!in_txn) noab_q <= req_noabort_i;
            end
            OP_END: begin
               depth_q <= depth_q - 1'b1;
               if (depth_q == DEPTH_ONE) begin
                  noab_q <= 1'b0;
                  ovf_q  <= 1'b0;
               end
            end
            OP_ABORT: begin
               depth_q <= '0;
               noab_q  <= 1'b0;
               ovf_q   <= 1'b0;
            end
            OP_ENTER: ovf_q <= 1'b1;
            default: ;
         endcase
      end
   end

   assign ovf_o     = ovf_q;
   assign depth_o   = depth_q;
   assign noabort_o = noab_q;

   // R5: an overflowed thread is always inside a transaction
   assert_ovf_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> in_txn);

   // R2: depth moves by one step, except the drop to zero on abort
   assert_depth_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_q != $past(depth_q)) |->
         ((depth_q == $past(depth_q) + 1'b1) || (depth_q == $past(depth_q) - 1'b1)
          || (depth_q == '0)));

   // R4: a thread never sees grant and stall together
   assert_resp_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o && stall_o));
endmodule

// File: rtl/solo_ovf_meta.sv
module solo_ovf_meta #(
   parameter int NUM_THREADS = 4,
   parameter int ID_W        = 8,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input  logic                   chk_valid_i,
   input  logic [TID_W-1:0]       chk_tid_i,
   input  logic                   chk_write_i,
   input  logic                   chk_owner_i,
   input  logic                   chk_rd_bit_i,
   input  logic                   chk_wr_bit_i,
   input  logic [ID_W-1:0]        chk_id_i,
   input  logic                   shared_active_i,
   input  logic [ID_W-1:0]        shared_id_i,
   input  logic [NUM_THREADS-1:0] thr_ovf_i,
   output logic                   live_o,
   output logic                   conflict_o,
   output logic                   wr_en_o,
   output logic                   rd_o,
   output logic                   wr_o
);
   logic req_ovf;
   logic hazard;

   always_comb begin
      req_ovf = 1'b0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (chk_tid_i == TID_W'(i)) req_ovf = thr_ovf_i[i];
      end
   end

   assign live_o     = shared_active_i && (chk_id_i == shared_id_i);
   assign hazard     = chk_wr_bit_i || (chk_write_i && chk_rd_bit_i);
   assign conflict_o = chk_valid_i && live_o && !req_ovf && hazard;
   assign wr_en_o    = chk_valid_i && chk_owner_i && req_ovf;
   assign rd_o       = (live_o && chk_rd_bit_i) || !chk_write_i;
   assign wr_o       = (live_o && chk_wr_bit_i) || chk_write_i;
endmodule

// File: rtl/solo_ovf_ctrl.sv
module solo_ovf_ctrl
   import solo_ovf_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int ID_W        = 8,
   parameter int DEPTH_W     = 4,
   parameter bit SERIALIZED  = 1'b1,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THREADS-1:0]         req_valid_i,
   input  logic [2*NUM_THREADS-1:0]       req_op_i,
   input  logic [NUM_THREADS-1:0]         req_noabort_i,
   output logic [NUM_THREADS-1:0]         grant_o,
   output logic [NUM_THREADS-1:0]         stall_o,
   output logic [NUM_THREADS-1:0]         hold_o,
   output logic                           ovf_active_o,
   output logic [ID_W-1:0]                ovf_id_o,
   output logic [TID_W-1:0]               ovf_holder_o,
   output logic [NUM_THREADS-1:0]         thr_ovf_o,
   output logic [DEPTH_W*NUM_THREADS-1:0] thr_depth_o,
   output logic [NUM_THREADS-1:0]         thr_noabort_o,
   input  logic                           chk_valid_i,
   input  logic [TID_W-1:0]               chk_tid_i,
   input  logic                           chk_write_i,
   input  logic                           chk_owner_i,
   input  logic                           chk_rd_bit_i,
   input  logic                           chk_wr_bit_i,
   input  logic [ID_W-1:0]                chk_id_i,
   output logic                           chk_live_o,
   output logic                           chk_conflict_o,
   output logic                           meta_wr_en_o,
   output logic                           meta_rd_o,
   output logic                           meta_wr_o,
   output logic [ID_W-1:0]                meta_id_o
);
   if (NUM_THREADS < 2) begin : g_bad_threads
      $error("solo_ovf_ctrl: NUM_THREADS must be at least 2");
   end
   if (ID_W < 1 || ID_W > 32) begin : g_bad_id
      $error("solo_ovf_ctrl: ID_W must be 1..32");
   end
   if (DEPTH_W < 1 || DEPTH_W > 16) begin : g_bad_depth
      $error("solo_ovf_ctrl: DEPTH_W must be 1..16");
   end

   localparam logic [NUM_THREADS-1:0] ONE_HOT0 = NUM_THREADS'(1);

   logic                   active_q;
   logic [ID_W-1:0]        id_q;
   logic [TID_W-1:0]       holder_q;
   logic [NUM_THREADS-1:0] cand;
   logic [NUM_THREADS-1:0] win;
   logic [NUM_THREADS-1:0] release_v;
   logic [NUM_THREADS-1:0] blocked;
   logic [TID_W-1:0]       win_idx;

   // variant choice: serialized holds every non-holder thread
   if (SERIALIZED) begin : g_serial
      for (genvar i = 0; i < NUM_THREADS; i++) begin : g_hold
         assign blocked[i] = active_q && (holder_q != TID_W'(i));
      end
   end else begin : g_concurrent
      assign blocked = '0;
   end
   assign hold_o = blocked;

   solo_ovf_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
      .cand_i (cand),
      .win_o  (win)
   );

   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
      solo_ovf_thread #(.DEPTH_W(DEPTH_W)) u_ctx (
         .clk             (clk),
         .rst_n           (rst_n),
         .req_valid_i     (req_valid_i[i]),
         .req_op_i        (txn_op_e'(req_op_i[2*i +: 2])),
         .req_noabort_i   (req_noabort_i[i]),
         .blocked_i       (blocked[i]),
         .shared_active_i (active_q),
         .entry_win_i     (win[i]),
         .grant_o         (grant_o[i]),
         .stall_o         (stall_o[i]),
         .entry_cand_o    (cand[i]),
         .release_o       (release_v[i]),
         .ovf_o           (thr_ovf_o[i]),
         .depth_o         (thr_depth_o[i*DEPTH_W +: DEPTH_W]),
         .noabort_o       (thr_noabort_o[i])
      );
   end

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (win[i]) win_idx = TID_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         id_q     <= '0;
         holder_q <= '0;
      end else if (|win) begin
         active_q <= 1'b1;
         id_q     <= id_q + 1'b1;
         holder_q <= win_idx;
      end else if (|release_v) begin
         active_q <= 1'b0;
      end
   end

   assign ovf_active_o = active_q;
   assign ovf_id_o     = id_q;
   assign ovf_holder_o = holder_q;
   assign meta_id_o    = id_q;

   solo_ovf_meta #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_meta (
      .chk_valid_i     (chk_valid_i),
      .chk_tid_i       (chk_tid_i),
      .chk_write_i     (chk_write_i),
      .chk_owner_i     (chk_owner_i),
      .chk_rd_bit_i    (chk_rd_bit_i),
      .chk_wr_bit_i    (chk_wr_bit_i),
      .chk_id_i        (chk_id_i),
      .shared_active_i (active_q),
      .shared_id_i     (id_q),
      .thr_ovf_i       (thr_ovf_o),
      .live_o          (chk_live_o),
      .conflict_o      (chk_conflict_o),
      .wr_en_o         (meta_wr_en_o),
      .rd_o            (meta_rd_o),
      .wr_o            (meta_wr_o)
   );

   // R3: never more than one overflowed thread
   assert_single_holder_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(thr_ovf_o) <= 1);

   // R3: shared flag agrees with the holder's private flag
   assert_holder_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (thr_ovf_o == (ONE_HOT0 << holder_q)));

   // R3: each overflow entry advances the live identifier by one
   assert_id_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> (id_q == $past(id_q) + 1'b1));

   // R5: release leaves the identifier alone
   assert_id_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> (id_q == $past(id_q)));

   // R7: a held thread is never granted
   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_hold_chk
      assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
         hold_o[i] |-> !grant_o[i]);
   end

   // R8: a conflict needs live metadata
   assert_conflict_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_conflict_o |-> chk_live_o);

   // R9: rewrite permission only for an owning requester during an overflow
   assert_meta_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      meta_wr_en_o |-> (chk_owner_i && active_q));
endmodule

// File: tb/solo_ovf_ctrl_test.sv
module solo_ovf_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 4;
   localparam int IDW  = 3;
   localparam int DW   = 2;
   localparam bit SER  = 1'b1;
   localparam int TW   = $clog2(N);
   localparam int DMAX = (1 << DW) - 1;
   localparam int IDMOD = 1 << IDW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    req_valid;
   logic [2*N-1:0]  req_op;
   logic [N-1:0]    req_na;
   logic [N-1:0]    grant, stall, hold;
   logic            active;
   logic [IDW-1:0]  id;
   logic [TW-1:0]   holder;
   logic [N-1:0]    t_ovf;
   logic [DW*N-1:0] t_depth;
   logic [N-1:0]    t_na;
   logic            c_valid, c_write, c_owner, c_rd, c_wr;
   logic [TW-1:0]   c_tid;
   logic [IDW-1:0]  c_id;
   logic            live, conflict, mwen, mrd, mwr;
   logic [IDW-1:0]  mid;

   bit b_v[N];
   int b_op[N];
   bit b_na[N];

   always_comb begin
      for (int i = 0; i < N; i++) begin
         req_valid[i]      = b_v[i];
         req_op[2*i +: 2]  = 2'(b_op[i]);
         req_na[i]         = b_na[i];
      end
   end

   solo_ovf_ctrl #(.NUM_THREADS(N), .ID_W(IDW), .DEPTH_W(DW), .SERIALIZED(SER)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_noabort_i(req_na),
      .grant_o(grant), .stall_o(stall), .hold_o(hold),
      .ovf_active_o(active), .ovf_id_o(id), .ovf_holder_o(holder),
      .thr_ovf_o(t_ovf), .thr_depth_o(t_depth), .thr_noabort_o(t_na),
      .chk_valid_i(c_valid), .chk_tid_i(c_tid), .chk_write_i(c_write),
      .chk_owner_i(c_owner), .chk_rd_bit_i(c_rd), .chk_wr_bit_i(c_wr),
      .chk_id_i(c_id), .chk_live_o(live), .chk_conflict_o(conflict),
      .meta_wr_en_o(mwen), .meta_rd_o(mrd), .meta_wr_o(mwr), .meta_id_o(mid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   bit m_active;
   int m_id;
   int m_holder;
   bit m_ovf[N];
   int m_depth[N];
   bit m_na[N];

   // responses captured in the last step
   bit cap_grant[N];
   bit cap_stall[N];
   bit cap_hold[N];
   bit cap_conflict, cap_live, cap_mwen, cap_mrd, cap_mwr;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic clear_reqs();
      for (int i = 0; i < N; i++) begin
         b_v[i] = 0; b_op[i] = 0; b_na[i] = 0;
      end
      c_valid = 0; c_tid = '0; c_write = 0; c_owner = 0; c_rd = 0; c_wr = 0; c_id = '0;
   endtask

   task automatic req(int t, int o, bit n);
      b_v[t] = 1; b_op[t] = o; b_na[t] = n;
   endtask

   task automatic check_state(string tag);
      chk(tag, "shared flag", active, m_active);
      chk(tag, "live id", id, m_id);
      if (m_active) chk(tag, "holder", holder, m_holder);
      for (int i = 0; i < N; i++) begin
         chk(tag, $sformatf("ovf[%0d]", i), t_ovf[i], m_ovf[i]);
         chk("R2", $sformatf("depth[%0d]", i), t_depth[i*DW +: DW], m_depth[i]);
         chk("R2", $sformatf("noabort[%0d]", i), t_na[i], m_na[i]);
      end
   endtask

   // one clock: compare responses, advance model, compare state
   task automatic step();
      bit eg[N];
      bit es[N];
      bit ec[N];
      int winner;
      bit lv, ho;
      #2;
      winner = -1;
      for (int i = 0; i < N; i++) begin
         bit blk;
         eg[i] = 0; es[i] = 0; ec[i] = 0;
         blk = SER && m_active && (m_holder != i);
         if (b_v[i]) begin
            if (blk) es[i] = 1;
            else if (b_op[i] == 0) eg[i] = (m_depth[i] < DMAX);
            else if (b_op[i] == 1) eg[i] = (m_depth[i] > 0);
            else if (b_op[i] == 2) eg[i] = (m_depth[i] > 0) && !m_na[i];
            else if (m_depth[i] > 0) begin
               if (m_ovf[i]) eg[i] = 1;
               else if (m_active) es[i] = 1;
               else ec[i] = 1;
            end
         end
         if (ec[i]) begin
            if (winner < 0) begin winner = i; eg[i] = 1; end
            else es[i] = 1;
         end
      end
      for (int i = 0; i < N; i++) begin
         chk("R4", $sformatf("grant[%0d]", i), grant[i], eg[i]);
         chk("R4", $sformatf("stall[%0d]", i), stall[i], es[i]);
         chk("R7", $sformatf("hold[%0d]", i), hold[i], SER && m_active && (m_holder != i));
         cap_grant[i] = grant[i]; cap_stall[i] = stall[i]; cap_hold[i] = hold[i];
      end
      lv = m_active && (int'(c_id) == m_id);
      ho = (int'(c_tid) < N) ? m_ovf[c_tid] : 0;
      chk("R8", "live", live, lv);
      chk("R8", "conflict", conflict, c_valid && lv && !ho && (c_wr || (c_write && c_rd)));
      chk("R9", "meta wr en", mwen, c_valid && c_owner && ho);
      chk("R9", "meta rd", mrd, (lv && c_rd) || !c_write);
      chk("R9", "meta wr", mwr, (lv && c_wr) || c_write);
      chk("R9", "meta id", mid, m_id);
      cap_conflict = conflict; cap_live = live; cap_mwen = mwen; cap_mrd = mrd; cap_mwr = mwr;
      // model update
      for (int i = 0; i < N; i++) begin
         if (eg[i]) begin
            case (b_op[i])
               0: begin
                  if (m_depth[i] == 0) m_na[i] = b_na[i];
                  m_depth[i]++;
               end
               1: begin
                  m_depth[i]--;
                  if (m_depth[i] == 0) begin
                     m_na[i] = 0;
                     if (m_ovf[i]) begin m_ovf[i] = 0; m_active = 0; end
                  end
               end
               2: begin
                  m_depth[i] = 0; m_na[i] = 0;
                  if (m_ovf[i]) begin m_ovf[i] = 0; m_active = 0; end
               end
               default: if (i == winner) begin
                  m_ovf[i] = 1; m_active = 1; m_holder = i; m_id = (m_id + 1) % IDMOD;
               end
            endcase
         end
      end
      @(posedge clk);
      #1;
      check_state("R3");
   endtask

   initial begin
      clear_reqs();
      m_active = 0; m_id = 0; m_holder = 0;
      for (int i = 0; i < N; i++) begin m_ovf[i] = 0; m_depth[i] = 0; m_na[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", "flag after reset", active, 0);
      chk("R1", "id after reset", id, 0);
      chk("R1", "ovf after reset", t_ovf, 0);
      chk("R1", "depth after reset", t_depth, 0);
      chk("R1", "noabort after reset", t_na, 0);
      chk("R1", "grant idle", grant, 0);
      chk("R1", "hold idle", hold, 0);

      // begins: t1 carries no-abort
      clear_reqs(); req(0, 0, 0); req(1, 0, 1); req(2, 0, 0); step();
      chk("R2", "t1 noabort latched", t_na[1], 1);

      // simultaneous entry t0 and t2: t0 wins
      clear_reqs(); req(2, 3, 0); req(0, 3, 0); step();
      chk("R4", "t0 wins entry", cap_grant[0], 1);
      chk("R4", "t2 stalled", cap_stall[2], 1);
      chk("R3", "id bumped", id, 1);
      chk("R3", "holder t0", holder, 0);

      // second entry stalled, t1 held
      clear_reqs(); req(2, 3, 0); req(1, 1, 0); step();
      chk("R4", "t2 entry stalled again", cap_stall[2], 1);
      chk("R7", "t1 held", cap_hold[1], 1);
      chk("R7", "t1 end stalled", cap_stall[1], 1);
      chk("R7", "t1 depth unchanged", t_depth[1*DW +: DW], 1);

      // metadata checks
      clear_reqs(); c_valid = 1; c_tid = 2'd1; c_rd = 0; c_wr = 1; c_id = id; step();
      chk("R8", "live write bit conflicts", cap_conflict, 1);
      clear_reqs(); c_valid = 1; c_tid = 2'd1; c_write = 1; c_rd = 1; c_id = id; step();
      chk("R8", "write after live read conflicts", cap_conflict, 1);
      clear_reqs(); c_valid = 1; c_tid = 2'd1; c_wr = 1; c_id = id + 1'b1; step();
      chk("R8", "stale id no conflict", cap_conflict, 0);
      clear_reqs(); c_valid = 1; c_tid = 2'd0; c_owner = 1; c_write = 1; c_rd = 1; c_wr = 0;
      c_id = id + 3'd2; step();
      chk("R9", "holder owner may rewrite", cap_mwen, 1);
      chk("R9", "stale read bit dropped", cap_mrd, 0);
      chk("R9", "write bit set", cap_mwr, 1);
      clear_reqs(); c_valid = 1; c_tid = 2'd0; c_owner = 0; c_wr = 1; c_id = id; step();
      chk("R9", "non-owner no rewrite", cap_mwen, 0);
      chk("R8", "holder no conflict", cap_conflict, 0);

      // nesting: t0 begin, end, end
      clear_reqs(); req(0, 0, 0); step();
      clear_reqs(); req(0, 1, 0); step();
      chk("R5", "inner end keeps flag", active, 1);
      clear_reqs(); req(0, 1, 0); step();
      chk("R5", "outer end clears flag", active, 0);
      chk("R5", "id kept on release", id, 1);
      clear_reqs(); c_valid = 1; c_tid = 2'd1; c_wr = 1; c_id = 3'd1; step();
      chk("R8", "metadata stale after release", cap_live, 0);

      // aborts
      clear_reqs(); req(1, 2, 0); req(2, 2, 0); step();
      chk("R6", "abort refused with noabort", cap_grant[1], 0);
      chk("R6", "t1 depth kept", t_depth[1*DW +: DW], 1);
      chk("R6", "abort granted", cap_grant[2], 1);
      chk("R6", "t2 depth zero", t_depth[2*DW +: DW], 0);
      clear_reqs(); req(1, 1, 0); step();

      // depth-zero requests refused
      clear_reqs(); req(2, 1, 0); req(1, 3, 0); req(3, 2, 0); step();
      chk("R10", "end at depth 0 no grant", cap_grant[2], 0);
      chk("R10", "end at depth 0 no stall", cap_stall[2], 0);
      chk("R10", "enter at depth 0 ignored", cap_grant[1] | cap_stall[1], 0);
      chk("R10", "abort at depth 0 ignored", cap_grant[3] | cap_stall[3], 0);
      chk("R10", "no flag raised", active, 0);

      // max depth
      for (int k = 0; k < DMAX + 1; k++) begin clear_reqs(); req(0, 0, 0); step(); end
      chk("R2", "begin at max refused", cap_grant[0], 0);
      chk("R2", "depth at max", t_depth[0 +: DW], DMAX);
      clear_reqs(); req(0, 2, 0); step();

      // identifier wrap with t3
      for (int k = 0; k < IDMOD + 1; k++) begin
         clear_reqs(); req(3, 0, 0); step();
         clear_reqs(); req(3, 3, 0); step();
         chk("R3", "wrapping id", id, m_id);
         clear_reqs(); req(3, 1, 0); step();
      end
      chk("R3", "id wrapped", id, (1 + IDMOD + 1) % IDMOD);

      // random phase
      for (int k = 0; k < 2000; k++) begin
         clear_reqs();
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(2) == 0) req(i, $urandom_range(3), $urandom_range(3) == 0);
         end
         c_valid = $urandom_range(1);
         c_tid = TW'($urandom_range(N - 1));
         c_write = $urandom_range(1); c_owner = $urandom_range(1);
         c_rd = $urandom_range(1); c_wr = $urandom_range(1);
         c_id = ($urandom_range(1) == 1) ? IDW'(m_id) : IDW'($urandom_range(IDMOD - 1));
         step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule